// File: doc/BRIEF.md
# Chroma Hue and Saturation Adjuster

This block sits on a stream of signed colour-difference sample pairs (U and V) that arrive with a valid strobe. It turns each pair through a programmable hue angle and then scales it by a programmable saturation gain. The adjusted pair leaves with its own valid strobe after a fixed pipeline delay. Two 8-bit settings control it: a gain code and a hue code. Both are written through a single-cycle write port and can be read back through a combinational read port.

The hue code spans one full turn in 256 steps of 1.40625 degrees. Sine and cosine come from a quarter-wave table that is built when the design is elaborated and folded into four quadrants. The gain is an unsigned fixed-point value with one integer bit and seven fraction bits. Every product is rounded half away from zero and clamped to the signed 10-bit sample range. With the reset settings the data path passes samples through unchanged.

Top module: `chroma_hue_sat`

## Requirements
- R1: After reset the gain setting reads 0x80 (unity), the hue setting reads 0x00, and out_valid is low.
- R2: A write with wr_sel=0 loads the gain setting and a write with wr_sel=1 loads the hue setting. Reading with the same rd_sel encoding returns the last value written, and a setting changes only when it is written.
- R3: With gain 0x80 and hue 0x00, out_u and out_v equal in_u and in_v bit for bit.
- R4: The output equals the rotated component times gain/128, so gain 0x00 gives zero and gain 0x40 gives half.
- R5: With angle = hue*360/256 degrees, the rotation is U' = U*cos + V*sin and V' = V*cos - U*sin. The coefficients are sine and cosine scaled by 1024 and rounded to the nearest integer. The sums are divided by 1024 before the gain is applied.
- R6: Each division (by 1024 after rotation, by 128 after gain) rounds half away from zero. For example, 1.5 becomes 2 and -1.5 becomes -2.
- R7: The rotated pair and the final pair are each clamped to the range -512 to +511.
- R8: A sample presented with in_valid high before clock edge n appears on the outputs, with out_valid high, right after edge n+2. That is three cycles after the cycle in which it was driven. out_valid is never high for a sample that was not sent.
- R9: A sample presented in the same cycle as a write uses the old settings. The next sample uses the new ones.
- R10: The hue code wraps over a full turn. Code 64 maps (U,V) to (V,-U), code 128 negates both components (subject to the R7 clamp), and code 255 is a small negative rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 1 | Write target: 0 gain, 1 hue |
| wr_data | input | 8 | Write value |
| rd_sel | input | 1 | Read select: 0 gain, 1 hue |
| rd_data | output | 8 | Selected setting, combinational |
| in_valid | input | 1 | Input sample strobe |
| in_u | input | 10 | Input U, two's complement |
| in_v | input | 10 | Input V, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_u | output | 10 | Adjusted U, two's complement |
| out_v | output | 10 | Adjusted V, two's complement |

## Verification
The data path is tried with identity settings at the range extremes, which shows whether any rounding or clamping leaks into a pass-through. Gain-only settings of half, zero and near two use odd and extreme samples: they separate round-half-away from truncation or round-to-even, and show the clamp at both rails. Hue codes 64, 128, 32 and 255 separate the sign convention of the rotation, the quadrant folding of the table and the wrap of the code. A write issued in the same cycle as a sample, and samples sent back to back and with gaps, show which settings a sample uses and that the delay is fixed.

// File: rtl/chs_pkg.sv
package chs_pkg;

   // Register select encoding shared by the write and read ports.
   typedef enum logic {
      SEL_GAIN = 1'b0,
      SEL_HUE  = 1'b1
   } chs_sel_e;

   // Quarter-wave sine coefficient: entry idx of a table of 'steps'
   // entries covering 90 degrees, scaled by 'scale' and rounded to nearest.
   function automatic int quarter_coef(input int idx, input int steps, input int scale);
      real ang;
      real val;
      ang = 6.283185307179586 * real'(idx) / (4.0 * real'(steps));
      val = real'(scale) * $sin(ang);
      return $rtoi(val + 0.5);
   endfunction

endpackage

// File: rtl/chs_ctrl_regs.sv
module chs_ctrl_regs #(
   parameter int REG_W  = 8,
   parameter int GAIN_W = 8,
   parameter int HUE_W  = 8,
   parameter logic [GAIN_W-1:0] GAIN_RST = '0,
   parameter logic [HUE_W-1:0]  HUE_RST  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_sel,
   output logic [REG_W-1:0]  rd_data,
   output logic [GAIN_W-1:0] gain_q,
   output logic [HUE_W-1:0]  hue_q
);
   import chs_pkg::*;

   if (GAIN_W > REG_W) begin : g_bad_gain
      $error("gain setting wider than register port");
   end
   if (HUE_W > REG_W) begin : g_bad_hue
      $error("hue setting wider than register port");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q <= GAIN_RST;
         hue_q  <= HUE_RST;
      end else if (wr_en) begin
         if (chs_sel_e'(wr_sel) == SEL_GAIN) gain_q <= wr_data[GAIN_W-1:0];
         else                                hue_q  <= wr_data[HUE_W-1:0];
      end
   end

   always_comb begin
      if (chs_sel_e'(rd_sel) == SEL_GAIN) rd_data = REG_W'(gain_q);
      else                                rd_data = REG_W'(hue_q);
   end

endmodule

// File: rtl/chs_trig_rom.sv
module chs_trig_rom #(
   parameter int HUE_W     = 8,
   parameter int COEF_W    = 12,
   parameter int COEF_FRAC = 10
) (
   input  logic [HUE_W-1:0]         code,
   output logic signed [COEF_W-1:0] sin_o,
   output logic signed [COEF_W-1:0] cos_o
);
   localparam int QSTEPS = 1 << (HUE_W - 2);
   localparam logic [HUE_W-2:0] QV = (HUE_W-1)'(QSTEPS);

   if (HUE_W < 3) begin : g_bad_hue
      $error("hue code needs at least three bits");
   end
   if (COEF_W < COEF_FRAC + 2) begin : g_bad_coef
      $error("coefficient width cannot hold plus and minus one");
   end

   logic signed [COEF_W-1:0] qtab [0:QSTEPS];
   logic signed [COEF_W-1:0] wave [2];

   for (genvar g = 0; g <= QSTEPS; g++) begin : g_qtab
      assign qtab[g] = COEF_W'(chs_pkg::quarter_coef(g, QSTEPS, 1 << COEF_FRAC));
   end

   // k=0 gives sine, k=1 gives cosine as sine advanced by a quarter turn.
   for (genvar k = 0; k < 2; k++) begin : g_wave
      logic [HUE_W-1:0]         phase;
      logic [HUE_W-3:0]         frac;
      logic [HUE_W-2:0]         idx;
      logic signed [COEF_W-1:0] mag;
      assign phase = code + HUE_W'(k * QSTEPS);
      assign frac  = phase[HUE_W-3:0];
      assign idx   = phase[HUE_W-2] ? (QV - {1'b0, frac}) : {1'b0, frac};
      assign mag   = qtab[idx];
      assign wave[k] = phase[HUE_W-1] ? -mag : mag;
   end

   assign sin_o = wave[0];
   assign cos_o = wave[1];

endmodule

// File: rtl/chs_round_sat.sv
module chs_round_sat #(
   parameter int IN_W  = 23,
   parameter int SHIFT = 10,
   parameter int OUT_W = 10
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   localparam int EW = IN_W + 2;
   localparam logic signed [EW-1:0] ONE  = EW'(1);
   localparam logic signed [EW-1:0] HALF = ONE <<< (SHIFT - 1);
   localparam logic signed [EW-1:0] MAXV = (ONE <<< (OUT_W - 1)) - ONE;
   localparam logic signed [EW-1:0] MINV = -(ONE <<< (OUT_W - 1));

   if (SHIFT < 1) begin : g_bad_shift
      $error("rounding shift must be at least one");
   end
   if (IN_W <= OUT_W) begin : g_bad_width
      $error("input must be wider than output");
   end

   logic signed [EW-1:0] wide;
   logic signed [EW-1:0] mag;
   logic signed [EW-1:0] rnd;
   logic signed [EW-1:0] res;

   assign wide = EW'(din);
   assign mag  = wide[EW-1] ? -wide : wide;
   assign rnd  = (mag + HALF) >>> SHIFT;
   assign res  = wide[EW-1] ? -rnd : rnd;

   always_comb begin
      if (res > MAXV)      dout = MAXV[OUT_W-1:0];
      else if (res < MINV) dout = MINV[OUT_W-1:0];
      else                 dout = res[OUT_W-1:0];
   end

endmodule

// File: rtl/chs_rotator.sv
module chs_rotator #(
   parameter int DATA_W    = 10,
   parameter int COEF_W    = 12,
   parameter int COEF_FRAC = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_u,
   input  logic signed [DATA_W-1:0] in_v,
   input  logic signed [COEF_W-1:0] cos_c,
   input  logic signed [COEF_W-1:0] sin_c,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_u,
   output logic signed [DATA_W-1:0] out_v
);
   localparam int SUM_W = DATA_W + COEF_W + 1;

   logic signed [SUM_W-1:0]  acc [2];
   logic signed [DATA_W-1:0] lim [2];

   assign acc[0] = in_u * cos_c + in_v * sin_c;
   assign acc[1] = in_v * cos_c - in_u * sin_c;

   for (genvar c = 0; c < 2; c++) begin : g_comp
      chs_round_sat #(.IN_W(SUM_W), .SHIFT(COEF_FRAC), .OUT_W(DATA_W)) u_rs (
         .din  (acc[c]),
         .dout (lim[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_u     <= '0;
         out_v     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_u <= lim[0];
            out_v <= lim[1];
         end
      end
   end

endmodule

// File: rtl/chs_gain_stage.sv
module chs_gain_stage #(
   parameter int DATA_W    = 10,
   parameter int GAIN_W    = 8,
   parameter int GAIN_FRAC = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_u,
   input  logic signed [DATA_W-1:0] in_v,
   input  logic [GAIN_W-1:0]        gain,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_u,
   output logic signed [DATA_W-1:0] out_v
);
   localparam int PROD_W = DATA_W + GAIN_W + 1;

   if (GAIN_FRAC >= GAIN_W) begin : g_bad_gain
      $error("gain needs at least one integer bit");
   end

   logic signed [GAIN_W:0]   gain_s;
   logic signed [DATA_W-1:0] comp [2];
   logic signed [PROD_W-1:0] prod [2];
   logic signed [DATA_W-1:0] lim  [2];

   assign gain_s  = $signed({1'b0, gain});
   assign comp[0] = in_u;
   assign comp[1] = in_v;

   for (genvar c = 0; c < 2; c++) begin : g_comp
      assign prod[c] = comp[c] * gain_s;
      chs_round_sat #(.IN_W(PROD_W), .SHIFT(GAIN_FRAC), .OUT_W(DATA_W)) u_rs (
         .din  (prod[c]),
         .dout (lim[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_u     <= '0;
         out_v     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_u <= lim[0];
            out_v <= lim[1];
         end
      end
   end

endmodule

// File: rtl/chroma_hue_sat.sv
module chroma_hue_sat #(
   parameter int DATA_W    = 10,
   parameter int COEF_W    = 12,
   parameter int COEF_FRAC = 10,
   parameter int GAIN_W    = 8,
   parameter int GAIN_FRAC = 7,
   parameter int HUE_W     = 8,
   parameter int REG_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_sel,
   output logic [REG_W-1:0]  rd_data,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_u,
   input  logic [DATA_W-1:0] in_v,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_u,
   output logic [DATA_W-1:0] out_v
);
   localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << GAIN_FRAC;

   if (DATA_W < 2) begin : g_bad_data
      $error("sample width too small");
   end

   logic [GAIN_W-1:0]        gain_q;
   logic [HUE_W-1:0]         hue_q;
   logic signed [COEF_W-1:0] sin_w, cos_w;

   chs_ctrl_regs #(
      .REG_W(REG_W), .GAIN_W(GAIN_W), .HUE_W(HUE_W),
      .GAIN_RST(GAIN_UNITY), .HUE_RST('0)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .gain_q(gain_q), .hue_q(hue_q)
   );

   chs_trig_rom #(.HUE_W(HUE_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_rom (
      .code(hue_q), .sin_o(sin_w), .cos_o(cos_w)
   );

   // Stage 1: sample and the settings in force for it are captured together.
   logic                     s1_valid;
   logic signed [DATA_W-1:0] s1_u, s1_v;
   logic signed [COEF_W-1:0] s1_sin, s1_cos;
   logic [GAIN_W-1:0]        s1_gain, s2_gain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_u     <= '0;
         s1_v     <= '0;
         s1_sin   <= '0;
         s1_cos   <= '0;
         s1_gain  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_u    <= $signed(in_u);
            s1_v    <= $signed(in_v);
            s1_sin  <= sin_w;
            s1_cos  <= cos_w;
            s1_gain <= gain_q;
         end
      end
   end

   // Stage 2: rotation; the gain travels alongside.
   logic                     rot_valid;
   logic signed [DATA_W-1:0] rot_u, rot_v;

   chs_rotator #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_rot (
      .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_u(s1_u), .in_v(s1_v),
      .cos_c(s1_cos), .sin_c(s1_sin),
      .out_valid(rot_valid), .out_u(rot_u), .out_v(rot_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        s2_gain <= '0;
      else if (s1_valid) s2_gain <= s1_gain;
   end

   // Stage 3: saturation gain.
   logic signed [DATA_W-1:0] fin_u, fin_v;

   chs_gain_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_gain (
      .clk(clk), .rst_n(rst_n), .in_valid(rot_valid), .in_u(rot_u), .in_v(rot_v),
      .gain(s2_gain), .out_valid(out_valid), .out_u(fin_u), .out_v(fin_v)
   );

   assign out_u = fin_u;
   assign out_v = fin_v;

endmodule

// File: rtl/chroma_hue_sat_chk.sv
module chroma_hue_sat_chk #(
   parameter int DATA_W    = 10,
   parameter int GAIN_W    = 8,
   parameter int GAIN_FRAC = 7,
   parameter int HUE_W     = 8,
   parameter int REG_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [REG_W-1:0]  wr_data,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_u,
   input logic [DATA_W-1:0] in_v,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_u,
   input logic [DATA_W-1:0] out_v,
   input logic [GAIN_W-1:0] gain_q,
   input logic [HUE_W-1:0]  hue_q
);
   localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << GAIN_FRAC;

   // Edges seen since reset, saturating at three.
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R1
   reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd0) |-> (gain_q == UNITY && hue_q == '0 && !out_valid));

   // R2
   gain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && $past(wr_en && !wr_sel)) |-> (gain_q == $past(wr_data[GAIN_W-1:0])));

   // R2
   setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !$past(wr_en)) |-> ($stable(gain_q) && $stable(hue_q)));

   // R8
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   // R3
   identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(in_valid && gain_q == UNITY && hue_q == '0, 3))
      |-> (out_u == $past(in_u, 3) && out_v == $past(in_v, 3)));

endmodule

bind chroma_hue_sat chroma_hue_sat_chk #(
   .DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .HUE_W(HUE_W), .REG_W(REG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .in_valid(in_valid), .in_u(in_u), .in_v(in_v),
   .out_valid(out_valid), .out_u(out_u), .out_v(out_v),
   .gain_q(gain_q), .hue_q(hue_q)
);

// File: tb/chroma_hue_sat_test.sv
`timescale 1ns/1ps
module chroma_hue_sat_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       in_valid = 1'b0;
   logic [9:0] in_u = '0, in_v = '0;
   logic       out_valid;
   logic [9:0] out_u, out_v;

   always #4 clk = ~clk;   // 125 MHz

   chroma_hue_sat uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .in_valid(in_valid), .in_u(in_u), .in_v(in_v),
      .out_valid(out_valid), .out_u(out_u), .out_v(out_v)
   );

   typedef struct { int u; int v; int stamp; string tag; } exp_t;
   exp_t sb[$];

   int checks = 0, fails = 0, cyc = 0;
   int m_gain = 128, m_hue = 0;

   always @(posedge clk) cyc++;

   function automatic longint rhaz(longint x, int sh);
      longint h = longint'(1) << (sh - 1);
      return (x >= 0) ? ((x + h) >>> sh) : -((-x + h) >>> sh);
   endfunction

   function automatic int clamp10(longint x);
      return (x > 511) ? 511 : (x < -512) ? -512 : int'(x);
   endfunction

   function automatic int coef(int code, bit want_cos);
      real a, x;
      a = 2.0 * 3.141592653589793 * real'(code) / 256.0;
      x = 1024.0 * (want_cos ? $cos(a) : $sin(a));
      return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
   endfunction

   function automatic int sx10(logic [9:0] b);
      return int'($signed(b));
   endfunction

   task automatic push_exp(int u, int v, string tag);
      exp_t e;
      int c, s, ru, rv;
      c = coef(m_hue, 1'b1);
      s = coef(m_hue, 1'b0);
      ru = clamp10(rhaz(longint'(u) * c + longint'(v) * s, 10));
      rv = clamp10(rhaz(longint'(v) * c - longint'(u) * s, 10));
      e.u = clamp10(rhaz(longint'(ru) * m_gain, 7));
      e.v = clamp10(rhaz(longint'(rv) * m_gain, 7));
      e.stamp = cyc;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic put(int u, int v, string tag);
      @(negedge clk);
      wr_en = 1'b0;
      in_valid = 1'b1;
      in_u = 10'(u);
      in_v = 10'(v);
      push_exp(u, v, tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en = 1'b0;
         in_valid = 1'b0;
      end
   endtask

   task automatic write_reg(bit sel, int data);
      @(negedge clk);
      in_valid = 1'b0;
      wr_en = 1'b1;
      wr_sel = sel;
      wr_data = 8'(data);
      if (sel) m_hue = data; else m_gain = data;
   endtask

   // Sample and write in the same cycle: the sample uses the old settings (R9).
   task automatic put_write(int u, int v, bit sel, int data, string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_u = 10'(u);
      in_v = 10'(v);
      push_exp(u, v, tag);
      wr_en = 1'b1;
      wr_sel = sel;
      wr_data = 8'(data);
      if (sel) m_hue = data; else m_gain = data;
   endtask

   task automatic check_reg(bit sel, int expv, string tag);
      @(negedge clk);
      wr_en = 1'b0;
      in_valid = 1'b0;
      rd_sel = sel;
      #1;
      checks++;
      if (int'(rd_data) != expv) begin
         fails++;
         $display("FAIL %s: rd_data=0x%02h expected 0x%02h", tag, rd_data, expv[7:0]);
      end
   endtask

   // Scoreboard monitor.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R8: out_valid with no sample pending (actual 1, expected 0)");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (sx10(out_u) != e.u || sx10(out_v) != e.v || (cyc - e.stamp) != 3) begin
               fails++;
               $display("FAIL %s: got (%0d,%0d) latency %0d, expected (%0d,%0d) latency 3",
                        e.tag, sx10(out_u), sx10(out_v), cyc - e.stamp, e.u, e.v);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: out_valid=%b expected 0", out_valid);
      end
      rst_n = 1'b1;
      check_reg(1'b0, 8'h80, "R1 gain reset");
      check_reg(1'b1, 8'h00, "R1 hue reset");

      // R3: identity at defaults, extremes included
      put(0, 0, "R3");
      put(511, -512, "R3");
      put(-512, 511, "R3");
      put(-1, 1, "R3");
      put(123, -77, "R3");
      idle(4);

      // R4/R6: gain one half, odd samples probe rounding
      write_reg(1'b0, 8'h40);
      check_reg(1'b0, 8'h40, "R2 gain readback");
      put(3, -3, "R6 half gain 1.5/-1.5");
      put(1, -1, "R6 half gain 0.5/-0.5");
      put(5, -5, "R6");
      idle(2);
      put(100, -100, "R4");
      idle(4);

      // R4: gain zero
      write_reg(1'b0, 8'h00);
      put(300, -200, "R4 zero gain");
      idle(4);

      // R7: gain near two clamps at both rails
      write_reg(1'b0, 8'hFF);
      put(511, -512, "R7 gain clamp");
      put(200, -200, "R7");
      idle(4);

      // R10: quarter turn
      write_reg(1'b0, 8'h80);
      write_reg(1'b1, 8'd64);
      check_reg(1'b1, 8'd64, "R2 hue readback");
      check_reg(1'b0, 8'h80, "R2 gain unchanged by hue write");
      put(100, 37, "R10 hue 64");
      put(-512, 5, "R10 hue 64");
      idle(4);

      // R10/R7: half turn, -512 negated clamps to 511
      write_reg(1'b1, 8'd128);
      put(-512, 200, "R7 R10 hue 128");
      put(45, -300, "R10 hue 128");
      idle(4);

      // R5: 45 degrees with gain, intermediate clamp
      write_reg(1'b1, 8'd32);
      write_reg(1'b0, 8'h90);
      put(511, 511, "R5 R7 hue 32");
      put(100, -50, "R5 hue 32");
      put(-321, 17, "R5 hue 32");
      idle(4);

      // R10: wrap to a small negative angle
      write_reg(1'b1, 8'd255);
      write_reg(1'b0, 8'h80);
      put(400, -250, "R10 hue 255");
      put(-7, 300, "R5 hue 255");
      idle(4);

      // R9: write in the same cycle as a sample
      write_reg(1'b1, 8'd0);
      put_write(200, -100, 1'b0, 8'h20, "R9 old gain");
      put(200, -100, "R9 new gain");
      put_write(-50, 60, 1'b1, 8'd64, "R9 old hue");
      put(-50, 60, "R9 new hue");
      idle(4);

      // R8: back-to-back then gapped samples
      write_reg(1'b0, 8'h80);
      write_reg(1'b1, 8'd10);
      for (int i = 0; i < 6; i++) put(i * 37 - 100, 90 - i * 29, "R8 burst");
      idle(1);
      put(7, 8, "R8 gap");
      idle(2);
      put(-9, 10, "R8 gap");
      idle(6);

      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R8: %0d samples never produced, expected 0", sb.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule